// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This block watches one external tamper pin. Software picks which transition of that pin counts as an intrusion: a rise or a fall. When that transition is seen, the block does two things on the same clock edge. It freezes a copy of the running time and date into stamp registers, and it raises a control output that removes standby power from battery-backed SRAM. Removing that power destroys the SRAM contents.

The pin first passes through a synchronizer and then through an edge detector. The block keeps only the first event after it is armed. A sticky status flag blocks any later capture until software clears the flag. The supply-cut output stays high until software writes an explicit restore command. The block sits in the clock/calendar register space and has a small write port and a combinational read port. The time base and the SRAM power switch are outside this block.

Top module: `tamper_capture`

## Requirements
- R1: After reset, every register reads zero and `sram_cut_o` is low. The registers are control (addr 0), status (addr 1), time stamp (addr 2) and date stamp (addr 3).
- R2: Rising mode is selected when control bit 1 is 0 and control bit 0 (enable) is 1. A low-to-high change on `tamper_i` sets status bit 0. A change applied before rising edge k is registered at edge k+2. The stamps then hold the `time_i` and `date_i` values that were present in the cycle just before edge k+2.
- R3: In falling mode (control bit 1 = 1, enabled), a high-to-low change on `tamper_i` is the event, with the same timing and capture as R2.
- R4: The transition opposite to the selected one sets no flag and captures nothing.
- R5: `sram_cut_o` and status bit 1 go high on the same edge that sets the flag.
- R6: While the flag is set, further events leave both stamps and the flag unchanged.
- R7: Writing 1 to status bit 0 clears the flag and re-arms capture. Writing 0 there has no effect.
- R8: The cut output stays high until 1 is written to control bit 2. That write drops the cut and leaves the flag and both stamps unchanged. Control bit 2 always reads 0.
- R9: While enable is 0, no event is detected and the flag holds its value. Turning enable on while the pin already sits at its post-transition level does not produce an event.
- R10: If an event and a status-clear write fall in the same cycle, the event wins: the flag stays set and new stamps are taken. If an event and a restore write fall in the same cycle, the cut stays high.
- R11: Control bits 0 and 1 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tamper_i | input | 1 | Asynchronous tamper pin |
| time_i | input | TIME_W | Running time of day, millisecond resolution |
| date_i | input | DATE_W | Running date |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational on address |
| sram_cut_o | output | 1 | Removes SRAM standby supply when high |

## Verification
A detected edge can land in the same cycle as a software write that would undo its effect. Those writes are a status clear, which re-arms capture, or a restore, which powers the SRAM back up. The bench counts the synchronizer and history stages so that it can put the write strobe exactly in the cycle where the edge is recognised. It then reads back the status and stamps and checks the rule that the event wins. The bench also checks that the stamp matches the time value from that specific cycle, using a free-running time counter so that a one-cycle slip shows up.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TIME  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_DATE  = 2'd3;

  localparam int unsigned CTRL_EN_BIT      = 0;
  localparam int unsigned CTRL_FALL_BIT    = 1;
  localparam int unsigned CTRL_RESTORE_BIT = 2;
  localparam int unsigned STAT_FLAG_BIT    = 0;
  localparam int unsigned STAT_CUT_BIT     = 1;

  typedef struct packed {
    logic fall;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tamper_edge.sv
module tamper_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic en_i,
  input  logic fall_i,
  output logic event_o
);
  logic prev_q;

  // history tracks the pin even while disabled, so arming never sees a stale level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  logic rise, fall;
  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  assign event_o = en_i & (fall_i ? fall : rise);
endmodule

// File: rtl/tamper_regs.sv
module tamper_regs
  import tamper_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned DATE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              event_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [DATE_W-1:0] date_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic              flag_o,
  output logic              cut_o,
  output logic [TIME_W-1:0] stamp_time_o,
  output logic [DATE_W-1:0] stamp_date_o
);
  ctrl_t             ctrl_q;
  logic              flag_q, cut_q;
  logic [TIME_W-1:0] stamp_time_q;
  logic [DATE_W-1:0] stamp_date_q;

  logic ctrl_wr, clr_wr, restore_wr, capture;
  assign ctrl_wr    = we_i && (addr_i == ADDR_CTRL);
  assign clr_wr     = we_i && (addr_i == ADDR_STAT) && wdata_i[STAT_FLAG_BIT];
  assign restore_wr = ctrl_wr && wdata_i[CTRL_RESTORE_BIT];
  // a clear in the event cycle re-arms first, so the event is kept
  assign capture    = event_i && (!flag_q || clr_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.en   <= wdata_i[CTRL_EN_BIT];
      ctrl_q.fall <= wdata_i[CTRL_FALL_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (capture) flag_q <= 1'b1;
    else if (clr_wr)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cut_q <= 1'b0;
    else if (capture)     cut_q <= 1'b1;
    else if (restore_wr)  cut_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_time_q <= '0;
      stamp_date_q <= '0;
    end else if (capture) begin
      stamp_time_q <= time_i;
      stamp_date_q <= date_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = ctrl_q.en;
        rdata_o[CTRL_FALL_BIT] = ctrl_q.fall;
      end
      ADDR_STAT: begin
        rdata_o[STAT_FLAG_BIT] = flag_q;
        rdata_o[STAT_CUT_BIT]  = cut_q;
      end
      ADDR_TIME: rdata_o = DATA_W'(stamp_time_q);
      ADDR_DATE: rdata_o = DATA_W'(stamp_date_q);
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o       = ctrl_q;
  assign flag_o       = flag_q;
  assign cut_o        = cut_q;
  assign stamp_time_o = stamp_time_q;
  assign stamp_date_o = stamp_date_q;
endmodule

// File: rtl/tamper_capture.sv
module tamper_capture
  import tamper_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TIME_W      = 32,
  parameter int unsigned DATE_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tamper_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [DATE_W-1:0] date_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sram_cut_o
);
  logic              pin_sync;
  logic              evt;
  ctrl_t             ctrl;
  logic              evt_flag;
  logic [TIME_W-1:0] stamp_time;
  logic [DATE_W-1:0] stamp_date;

  tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tamper_i),
    .q_o    (pin_sync)
  );

  tamper_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (pin_sync),
    .en_i    (ctrl.en),
    .fall_i  (ctrl.fall),
    .event_o (evt)
  );

  tamper_regs #(.DATA_W(DATA_W), .TIME_W(TIME_W), .DATE_W(DATE_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .event_i      (evt),
    .time_i       (time_i),
    .date_i       (date_i),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .ctrl_o       (ctrl),
    .flag_o       (evt_flag),
    .cut_o        (sram_cut_o),
    .stamp_time_o (stamp_time),
    .stamp_date_o (stamp_date)
  );
endmodule

// File: rtl/tamper_capture_chk.sv
module tamper_capture_chk
  import tamper_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned DATE_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              flag_i,
  input logic              cut_i,
  input logic [TIME_W-1:0] time_i,
  input logic [DATE_W-1:0] date_i,
  input logic [TIME_W-1:0] stamp_time_i,
  input logic [DATE_W-1:0] stamp_date_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i
);
  logic clr_wr, restore_wr;
  assign clr_wr     = we_i && (addr_i == ADDR_STAT) && wdata_i[STAT_FLAG_BIT];
  assign restore_wr = we_i && (addr_i == ADDR_CTRL) && wdata_i[CTRL_RESTORE_BIT];

  // R5
  flag_cut_same_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> cut_i);

  // R2
  stamp_matches_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> (stamp_time_i == $past(time_i)) && (stamp_date_i == $past(date_i)));

  // R6
  stamp_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(stamp_time_i) || !$stable(stamp_date_i)) |-> $past(!flag_i || clr_wr));

  // R9
  no_event_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(en_i));

  // R8
  cut_release_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cut_i) |-> $past(restore_wr));

  // R7
  flag_clear_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_i) |-> $past(clr_wr));
endmodule

bind tamper_capture tamper_capture_chk #(
  .DATA_W(DATA_W), .TIME_W(TIME_W), .DATE_W(DATE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (ctrl.en),
  .flag_i       (evt_flag),
  .cut_i        (sram_cut_o),
  .time_i       (time_i),
  .date_i       (date_i),
  .stamp_time_i (stamp_time),
  .stamp_date_i (stamp_date),
  .we_i         (reg_we_i),
  .addr_i       (reg_addr_i),
  .wdata_i      (reg_wdata_i)
);

// File: tb/tamper_capture_bench.sv
module tamper_capture_bench;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_TIME = 2'd2, A_DATE = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tamper = 1'b0;
  logic [31:0] time_v = 32'h0;
  logic [31:0] date_v = 32'h2024_0101;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        cut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  // free-running time base, updated away from the active edge
  always @(negedge clk) time_v <= time_v + 32'd1;

  tamper_capture u_tamper_capture (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tamper_i    (tamper),
    .time_i      (time_v),
    .date_i      (date_v),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .sram_cut_o  (cut)
  );

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    tick();
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic settle();
    for (int i = 0; i < 5; i++) tick();
  endtask

  // drive pin to lvl, check flag low for two edges, optional write in the event cycle;
  // returns time presented in the recognising cycle
  task automatic fire(input logic lvl, input string req, input logic do_wr,
                      input logic [1:0] wa, input logic [31:0] wd,
                      input logic flag_before, output logic [31:0] tcap);
    logic [31:0] v;
    tick();
    tamper = lvl;
    tick();
    rd(A_STAT, v); check({req, " flag before sync"}, {31'b0, v[0]}, {31'b0, flag_before});
    tick();
    rd(A_STAT, v); check({req, " flag one edge early"}, {31'b0, v[0]}, {31'b0, flag_before});
    tcap = time_v;
    if (do_wr) begin we = 1'b1; addr = wa; wdata = wd; end
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    rd(A_STAT, v); check("R1 status", v, 32'h0);
    rd(A_TIME, v); check("R1 time stamp", v, 32'h0);
    rd(A_DATE, v); check("R1 date stamp", v, 32'h0);
    check("R1 cut", {31'b0, cut}, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] v, tc;
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, v); check("R11 ctrl readback", v, 32'h1);
    settle();
    fire(1'b1, "R2", 1'b0, 2'd0, 32'h0, 1'b0, tc);
    rd(A_STAT, v); check("R2 flag set", v, 32'h3);
    check("R5 cut with flag", {31'b0, cut}, 32'h1);
    rd(A_TIME, v); check("R2 time stamp", v, tc);
    rd(A_DATE, v); check("R2 date stamp", v, date_v);
  endtask

  task automatic t_first_only();
    logic [31:0] t0, d0, v;
    rd(A_TIME, t0); rd(A_DATE, d0);
    date_v = 32'h2025_0707;
    tick(); tamper = 1'b0; settle();
    tick(); tamper = 1'b1; settle();
    rd(A_TIME, v); check("R6 time kept", v, t0);
    rd(A_DATE, v); check("R6 date kept", v, d0);
    rd(A_STAT, v); check("R6 flag kept", v, 32'h3);
  endtask

  task automatic t_clear_restore();
    logic [31:0] t0, v;
    rd(A_TIME, t0);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R7 write 0 no effect", v, 32'h3);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R7 cleared, cut held R8", v, 32'h2);
    check("R8 cut still high", {31'b0, cut}, 32'h1);
    wr(A_CTRL, 32'h5);
    check("R8 cut released", {31'b0, cut}, 32'h0);
    rd(A_STAT, v); check("R8 status after restore", v, 32'h0);
    rd(A_TIME, v); check("R8 stamp untouched", v, t0);
    rd(A_CTRL, v); check("R8 restore bit reads 0", v, 32'h1);
  endtask

  task automatic t_fall_mode();
    logic [31:0] v, tc;
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, v); check("R11 ctrl fall disabled", v, 32'h2);
    tick(); tamper = 1'b0; settle();
    rd(A_STAT, v); check("R9 disabled no event", v, 32'h0);
    wr(A_CTRL, 32'h3); settle();
    rd(A_STAT, v); check("R9 no event on arming", v, 32'h0);
    tick(); tamper = 1'b1; settle();
    rd(A_STAT, v); check("R4 rise ignored in fall mode", v, 32'h0);
    check("R4 cut low", {31'b0, cut}, 32'h0);
    date_v = 32'h2026_1231;
    fire(1'b0, "R3", 1'b0, 2'd0, 32'h0, 1'b0, tc);
    rd(A_STAT, v); check("R3 flag set", v, 32'h3);
    rd(A_TIME, v); check("R3 time stamp", v, tc);
    rd(A_DATE, v); check("R3 date stamp", v, date_v);
  endtask

  task automatic t_conflict();
    logic [31:0] v, tc;
    wr(A_CTRL, 32'h1);
    date_v = 32'h2030_0202;
    // flag and cut are set; clear lands in the event cycle
    fire(1'b1, "R10 clear", 1'b1, A_STAT, 32'h1, 1'b1, tc);
    rd(A_STAT, v); check("R10 event beats clear", v, 32'h3);
    rd(A_TIME, v); check("R10 new time stamp", v, tc);
    rd(A_DATE, v); check("R10 new date stamp", v, date_v);
    wr(A_STAT, 32'h1);
    tick(); tamper = 1'b0; settle();
    rd(A_STAT, v); check("R4 fall ignored in rise mode", v, 32'h2);
    fire(1'b1, "R10 restore", 1'b1, A_CTRL, 32'h5, 1'b0, tc);
    check("R10 event beats restore", {31'b0, cut}, 32'h1);
    rd(A_STAT, v); check("R10 flag after restore clash", v, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_rise();
    t_first_only();
    t_clear_restore();
    t_fall_mode();
    t_conflict();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule